// File: doc/BRIEF.md
# Configurable Asynchronous Character Transmitter

This block converts a parallel character into a start/stop serial frame on one output line. The line rests at mark (1) while idle. Each frame has three parts:

- a single space (0) unit as the start element;
- the data bits, least significant first;
- a mark stop period.

All timing comes from an enable tick that runs at eight times the bit rate. One bit unit is therefore eight ticks, and half a unit is four ticks. Two static inputs set the frame shape. One picks a 5-bit or an 8-bit character. The other sets the stop period to one unit, one and a half units, or two units.

A ready flag tells the host when it may hand over the next character. The flag rises four ticks into the stop period. The host then pulses the load strobe, which captures the character and clears the flag. Because the flag rises early, the next character can wait inside the block during the rest of the stop period. It then starts at once when the stop period ends, so back-to-back frames have exactly the configured stop length between them.

A wait input holds a loaded character back, for half-duplex use. A power-clear input forces the block to idle. A strobed flag output gives the flag gated by a query input.

Top module: `async_char_tx`

## Requirements
- R1: While pwrClr is high and after it falls, serOut is mark (1) and flag is 1 until a character is loaded.
- R2: A frame begins with serOut at 0 for exactly 8 ticks. Each data bit then holds for 8 ticks, with dataIn[0] sent first, and a data bit of 1 is sent as 1. The block advances only on clocks where tick is high.
- R3: With wideMode = 0, only dataIn[4:0] is sent (5 data units) before the stop period. dataIn[7:5] is ignored.
- R4: With wideMode = 1, dataIn[7:0] is sent (8 data units) before the stop period.
- R5: The stop period is mark for 8 ticks when stopSel = 0, 12 ticks when stopSel = 1, and 16 ticks when stopSel = 2 or 3. When a character is already waiting, the next start element follows immediately after that period.
- R6: flag rises exactly 4 ticks after the stop period begins and is never high during the start or data elements.
- R7: A loadStb pulse while flag = 1 captures dataIn and clears flag on the next clock edge. A loadStb while flag = 0 is ignored: the frame in progress is unchanged and no extra frame is sent.
- R8: While waitIn = 1, a loaded character does not start, and serOut stays mark. Its frame starts on a tick after waitIn falls.
- R9: Raising waitIn during a frame does not change that frame's bits or timing.
- R10: flagStrobed is 1 exactly when flag = 1 and flagQuery = 1.
- R11: Asserting pwrClr during a frame aborts it: serOut returns to mark, flag returns to 1, and the aborted character is never resumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwrClr | input | 1 | Synchronous power-clear, active high |
| tick | input | 1 | Enable at eight times the bit rate |
| loadStb | input | 1 | Load strobe for the parallel character |
| dataIn | input | 8 | Parallel character, bit 0 sent first |
| wideMode | input | 1 | 1 = 8 data bits, 0 = 5 data bits |
| stopSel | input | 2 | Stop period: 0 = 1.0, 1 = 1.5, 2 or 3 = 2.0 units |
| waitIn | input | 1 | Holds a loaded character back from starting |
| flagQuery | input | 1 | Gate for the strobed flag output |
| serOut | output | 1 | Serial line, 1 = mark |
| flag | output | 1 | Ready for a new character |
| flagStrobed | output | 1 | flag gated by flagQuery |

## Verification
The embedded assertions check the following on every cycle:

- the control state does not move without a tick;
- the flag falls only in answer to a load;
- the flag is never set during a start element;
- a held character never leaves idle while wait is high;
- the strobes to the datapath are exclusive;
- a capture only happens while the line is at mark.

The following can only be shown by the bench scenarios, which sample the line at the centre of each unit and measure the mark gap between chained frames:

- the bit order and the per-width bit count;
- the exact stop lengths, including the 1.5-unit case;
- the position of the flag's rise;
- that a mid-frame wait or a stray load leaves a frame intact;
- that a mid-frame power-clear does not resume the character.

// File: rtl/async_char_tx_pkg.sv
package async_char_tx_pkg;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_START = 2'd1,
    TX_DATA  = 2'd2,
    TX_STOP  = 2'd3
  } txState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch parallel character
    logic goStart;   // drive start (space) element
    logic firstBit;  // drive data bit 0
    logic nextBit;   // shift and drive following data bit
    logic goMark;    // drive stop (mark) element
  } txStrobe_t;

  localparam logic [1:0] STOP_ONE  = 2'd0;
  localparam logic [1:0] STOP_HALF = 2'd1;

endpackage

// File: rtl/async_char_tx_dp.sv
module async_char_tx_dp
  import async_char_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              pwrClr,
  input  txStrobe_t         strb,
  input  logic [DATA_W-1:0] dataIn,
  output logic              serOut
);

  logic [DATA_W-1:0] dataReg;
  logic              lineReg;

  always_ff @(posedge clk) begin
    if (pwrClr) begin
      dataReg <= '0;
      lineReg <= 1'b1;
    end else begin
      if (strb.capture) dataReg <= dataIn;
      if (strb.goStart) lineReg <= 1'b0;
      if (strb.firstBit) lineReg <= dataReg[0];
      if (strb.nextBit) begin
        lineReg <= dataReg[1];
        dataReg <= dataReg >> 1;
      end
      if (strb.goMark) lineReg <= 1'b1;
    end
  end

  assign serOut = lineReg;

  // R2
  one_strobe_chk: assert property (@(posedge clk) disable iff (pwrClr)
    $onehot0({strb.goStart, strb.firstBit, strb.nextBit, strb.goMark}));

  // R7
  capture_on_mark_chk: assert property (@(posedge clk) disable iff (pwrClr)
    strb.capture |-> serOut);

endmodule

// File: rtl/async_char_tx_ctl.sv
module async_char_tx_ctl
  import async_char_tx_pkg::*;
#(
  parameter int DATA_W         = 8,
  parameter int NARROW_W       = 5,
  parameter int TICKS_PER_UNIT = 8
) (
  input  logic       clk,
  input  logic       pwrClr,
  input  logic       tick,
  input  logic       loadStb,
  input  logic       wideMode,
  input  logic [1:0] stopSel,
  input  logic       waitIn,
  output txStrobe_t  strb,
  output logic       flag
);

  localparam int CNT_W = $clog2(2 * TICKS_PER_UNIT);
  localparam int BIT_W = $clog2(DATA_W);
  localparam int HALF  = TICKS_PER_UNIT / 2;
  localparam logic [CNT_W-1:0] UNIT_LAST = CNT_W'(TICKS_PER_UNIT - 1);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(HALF - 1);
  localparam logic [CNT_W-1:0] STOP1_LAST = CNT_W'(TICKS_PER_UNIT - 1);
  localparam logic [CNT_W-1:0] STOP15_LAST = CNT_W'(TICKS_PER_UNIT + HALF - 1);
  localparam logic [CNT_W-1:0] STOP2_LAST = CNT_W'(2 * TICKS_PER_UNIT - 1);
  localparam logic [BIT_W-1:0] WIDE_LAST = BIT_W'(DATA_W - 1);
  localparam logic [BIT_W-1:0] NARROW_LAST = BIT_W'(NARROW_W - 1);

  txState_e         state;
  logic [CNT_W-1:0] subCnt;
  logic [BIT_W-1:0] bitIdx;
  logic             pending;

  logic [CNT_W-1:0] stopLast;
  logic [BIT_W-1:0] bitLast;
  logic             accept, unitEnd, stopEnd, startNow;

  always_comb begin
    case (stopSel)
      STOP_ONE:  stopLast = STOP1_LAST;
      STOP_HALF: stopLast = STOP15_LAST;
      default:   stopLast = STOP2_LAST;
    endcase
    bitLast  = wideMode ? WIDE_LAST : NARROW_LAST;
    accept   = loadStb && flag;
    unitEnd  = tick && (subCnt == UNIT_LAST);
    stopEnd  = tick && (state == TX_STOP) && (subCnt == stopLast);
    startNow = tick && pending && !waitIn &&
               ((state == TX_IDLE) || stopEnd);

    strb          = '0;
    strb.capture  = accept;
    strb.goStart  = startNow;
    strb.firstBit = (state == TX_START) && unitEnd;
    strb.nextBit  = (state == TX_DATA) && unitEnd && (bitIdx != bitLast);
    strb.goMark   = (state == TX_DATA) && unitEnd && (bitIdx == bitLast);
  end

  always_ff @(posedge clk) begin
    if (pwrClr) begin
      state   <= TX_IDLE;
      subCnt  <= '0;
      bitIdx  <= '0;
      flag    <= 1'b1;
      pending <= 1'b0;
    end else begin
      if (accept) begin
        flag    <= 1'b0;
        pending <= 1'b1;
      end
      if (startNow) begin
        state   <= TX_START;
        subCnt  <= '0;
        pending <= 1'b0;
      end else if (tick) begin
        case (state)
          TX_START: begin
            if (unitEnd) begin
              state  <= TX_DATA;
              subCnt <= '0;
              bitIdx <= '0;
            end else begin
              subCnt <= subCnt + 1'b1;
            end
          end
          TX_DATA: begin
            if (unitEnd) begin
              subCnt <= '0;
              if (bitIdx == bitLast) state <= TX_STOP;
              else bitIdx <= bitIdx + 1'b1;
            end else begin
              subCnt <= subCnt + 1'b1;
            end
          end
          TX_STOP: begin
            if (subCnt == HALF_LAST) flag <= 1'b1;
            if (subCnt == stopLast) begin
              state  <= TX_IDLE;
              subCnt <= '0;
            end else begin
              subCnt <= subCnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R7
  flag_fall_on_load_chk: assert property (@(posedge clk) disable iff (pwrClr)
    $fell(flag) |-> $past(loadStb));

  // R6
  start_flag_clear_chk: assert property (@(posedge clk) disable iff (pwrClr)
    (state == TX_START) |-> !flag);

  // R8
  wait_holds_idle_chk: assert property (@(posedge clk) disable iff (pwrClr)
    (state == TX_IDLE && waitIn) |=> (state == TX_IDLE));

  // R2
  no_tick_stable_chk: assert property (@(posedge clk) disable iff (pwrClr)
    !tick |=> $stable(state));

endmodule

// File: rtl/async_char_tx.sv
module async_char_tx
  import async_char_tx_pkg::*;
#(
  parameter int DATA_W         = 8,
  parameter int NARROW_W       = 5,
  parameter int TICKS_PER_UNIT = 8
) (
  input  logic              clk,
  input  logic              pwrClr,
  input  logic              tick,
  input  logic              loadStb,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              wideMode,
  input  logic [1:0]        stopSel,
  input  logic              waitIn,
  input  logic              flagQuery,
  output logic              serOut,
  output logic              flag,
  output logic              flagStrobed
);

  txStrobe_t strb;

  async_char_tx_ctl #(
    .DATA_W(DATA_W), .NARROW_W(NARROW_W), .TICKS_PER_UNIT(TICKS_PER_UNIT)
  ) ctl_i (
    .clk(clk), .pwrClr(pwrClr), .tick(tick), .loadStb(loadStb),
    .wideMode(wideMode), .stopSel(stopSel), .waitIn(waitIn),
    .strb(strb), .flag(flag)
  );

  async_char_tx_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .pwrClr(pwrClr), .strb(strb), .dataIn(dataIn), .serOut(serOut)
  );

  assign flagStrobed = flag & flagQuery;

endmodule

// File: tb/async_char_tx_tb_top.sv
module async_char_tx_tb_top;

  typedef struct {
    logic [7:0] data;
    logic       wide;
    logic [1:0] stop;
    bit         tight;
  } txItem_t;

  logic       clk = 1'b0;
  logic       pwrClr = 1'b1;
  logic       tick = 1'b0;
  logic       loadStb = 1'b0;
  logic [7:0] dataIn = '0;
  logic       wideMode = 1'b1;
  logic [1:0] stopSel = 2'd0;
  logic       waitIn = 1'b0;
  logic       flagQuery = 1'b0;
  logic       serOut, flag, flagStrobed;

  int  total = 0;
  int  bad = 0;
  bit  monEn = 1'b0;
  bit  done = 1'b0;
  txItem_t expQ[$];

  always #4 clk = ~clk;
  always @(negedge clk) tick <= ~tick;

  async_char_tx dut_i (
    .clk(clk), .pwrClr(pwrClr), .tick(tick), .loadStb(loadStb), .dataIn(dataIn),
    .wideMode(wideMode), .stopSel(stopSel), .waitIn(waitIn), .flagQuery(flagQuery),
    .serOut(serOut), .flag(flag), .flagStrobed(flagStrobed)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int stopClk(input logic [1:0] s);
    return (s == 2'd0) ? 16 : (s == 2'd1) ? 24 : 32;
  endfunction

  // driver: waits for flag, pushes expectation, pulses load
  task automatic sendChar(input logic [7:0] d, input logic w, input logic [1:0] s,
                          input bit tight);
    txItem_t it;
    while (!flag) @(negedge clk);
    if (!tight) begin
      repeat (40) @(negedge clk);
      wideMode = w;
      stopSel  = s;
    end
    it.data = d; it.wide = w; it.stop = s; it.tight = tight;
    expQ.push_back(it);
    dataIn  = d;
    loadStb = 1'b1;
    @(negedge clk);
    loadStb = 1'b0;
  endtask

  // monitor: detects start elements and compares against the queue
  initial begin : monitor
    int markRun;
    markRun = 0;
    forever begin
      @(negedge clk);
      if (!monEn || pwrClr) markRun = 0;
      else if (serOut) markRun++;
      else if (expQ.size() == 0) begin
        check(1'b0, "R7 unexpected frame", 1, 0);
        while (!serOut) @(negedge clk);
        markRun = 0;
      end else begin
        txItem_t it;
        int nb;
        it = expQ.pop_front();
        if (it.tight)
          check(markRun == stopClk(it.stop), "R5 stop gap", markRun, stopClk(it.stop));
        repeat (8) @(negedge clk);
        check(serOut == 1'b0, "R2 start element", serOut, 0);
        nb = it.wide ? 8 : 5;
        for (int i = 0; i < nb; i++) begin
          repeat (16) @(negedge clk);
          if (it.wide) check(serOut == it.data[i], "R4 data bit", serOut, it.data[i]);
          else check(serOut == it.data[i], "R3 data bit", serOut, it.data[i]);
        end
        repeat (8) @(negedge clk);
        check(serOut == 1'b1, "R2 stop mark", serOut, 1);
        repeat (7) @(negedge clk);
        check(flag == 1'b0, "R6 flag before half unit", flag, 0);
        @(negedge clk);
        check(flag == 1'b1, "R6 flag at half unit", flag, 1);
        markRun = 9;
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    bit held;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(serOut == 1'b1, "R1 line mark in reset", serOut, 1);
    check(flag == 1'b1, "R1 flag in reset", flag, 1);
    pwrClr = 1'b0;
    @(negedge clk);
    check(serOut == 1'b1 && flag == 1'b1, "R1 idle after reset", {serOut, flag}, 3);
    // R10 strobed flag
    flagQuery = 1'b1;
    #1 check(flagStrobed == 1'b1, "R10 strobed flag high", flagStrobed, 1);
    flagQuery = 1'b0;
    #1 check(flagStrobed == 1'b0, "R10 strobed flag gated", flagStrobed, 0);
    monEn = 1'b1;

    sendChar(8'hA5, 1'b1, 2'd0, 1'b0);
    flagQuery = 1'b1;
    @(negedge clk);
    check(flag == 1'b0, "R7 flag clears on load", flag, 0);
    check(flagStrobed == 1'b0, "R10 strobed flag while busy", flagStrobed, 0);
    flagQuery = 1'b0;
    sendChar(8'h3C, 1'b1, 2'd0, 1'b1);
    sendChar(8'h96, 1'b0, 2'd1, 1'b0);
    sendChar(8'h0B, 1'b0, 2'd1, 1'b1);
    sendChar(8'hFF, 1'b1, 2'd2, 1'b0);
    sendChar(8'h00, 1'b1, 2'd2, 1'b1);
    sendChar(8'h81, 1'b1, 2'd3, 1'b0);
    sendChar(8'h7E, 1'b1, 2'd3, 1'b1);

    // R8 wait holds a loaded character
    while (!flag) @(negedge clk);
    repeat (40) @(negedge clk);
    waitIn = 1'b1;
    sendChar(8'h55, 1'b1, 2'd0, 1'b0);
    held = 1'b1;
    repeat (150) begin
      @(negedge clk);
      if (!serOut) held = 1'b0;
    end
    check(held, "R8 line held at mark", held, 1);
    waitIn = 1'b0;

    // R9 wait mid-frame, R7 stray load ignored
    sendChar(8'hC3, 1'b1, 2'd1, 1'b0);
    repeat (60) @(negedge clk);
    waitIn  = 1'b1;
    dataIn  = 8'h00;
    loadStb = 1'b1;
    @(negedge clk);
    loadStb = 1'b0;
    check(flag == 1'b0, "R7 stray load ignored", flag, 0);
    while (!flag) @(negedge clk);
    waitIn = 1'b0;

    while (expQ.size() != 0) @(negedge clk);
    repeat (300) @(negedge clk);
    check(serOut == 1'b1 && flag == 1'b1, "R7 no extra frame", {serOut, flag}, 3);

    // R11 power-clear mid-frame
    monEn = 1'b0;
    dataIn  = 8'h00;
    loadStb = 1'b1;
    @(negedge clk);
    loadStb = 1'b0;
    repeat (50) @(negedge clk);
    check(serOut == 1'b0, "R11 frame running", serOut, 0);
    pwrClr = 1'b1;
    @(negedge clk);
    pwrClr = 1'b0;
    check(serOut == 1'b1 && flag == 1'b1, "R11 abort to idle", {serOut, flag}, 3);
    held = 1'b1;
    repeat (300) begin
      @(negedge clk);
      if (!serOut) held = 1'b0;
    end
    check(held, "R11 no resume", held, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule